// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns an asynchronous serial input line into parallel characters. The line is examined on an oversampling strobe that runs at sixteen times the bit rate. A start bit counts only when three consecutive samples, taken after a seven-strobe wait from the first low level, all read low. Every bit after the start bit is decided by a two-of-three vote over three samples near its centre, so a single disturbed sample cannot change a bit.

The character may carry seven, eight or nine data bits, with an optional parity bit and one or two stop bits. A finished character moves into a holding buffer, and that raises a ready flag. The buffer stays valid until the consumer acknowledges it, so the next character can arrive in the meantime. The buffer also records parity, framing and break conditions for its character. A separate overrun flag is set if a further character arrives while the buffer is still full. The strobe comes from an external rate divider, and the consumer reads the buffer through the output pins.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, rx_ready, err_parity, err_frame, err_overrun and break_det are 0 and rx_data is 0. The input rx_in passes through a two-flop synchronizer, and its idle level is high.
- R2: In idle, a tick16 strobe that finds the synchronized line low starts a start-bit check. The line is sampled on the 7th, 8th and 9th strobes after that one. The start bit is accepted only if all three samples are low. Otherwise the receiver returns to idle and delivers no character.
- R3: Each bit after the start bit lasts 16 strobes. It is sampled on strobes 7, 8 and 9 of its bit time, and its value is the one that at least two of the three samples agree on.
- R4: cfg_dbits selects the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits and 3 gives 8 bits. Data arrives least significant bit first and is placed in rx_data[8:0], with unused upper bits set to 0.
- R5: When cfg_par_en is 1, one parity bit follows the data. With cfg_par_odd=0 the data ones plus the parity bit must be even in number, and with cfg_par_odd=1 they must be odd. A mismatch sets err_parity for that character.
- R6: cfg_two_stop=0 selects one stop bit and 1 selects two. err_frame is set when the first stop bit votes low. The value of the second stop bit is not checked.
- R7: On the vote of the final stop bit, the character and its flags move into the buffer, and rx_ready rises on the next clock. rx_ready and the flags then hold until a one-cycle rd_ack pulse, which clears rx_ready, err_parity, err_frame, break_det and err_overrun. rx_data keeps its value.
- R8: A character that completes while rx_ready is 1 and rd_ack is 0 sets err_overrun. The buffered data and its flags stay unchanged.
- R9: break_det is set when every data bit, the parity bit (if enabled) and the first stop bit all vote low. err_frame is set together with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling strobe, one clock wide, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| cfg_dbits | input | 2 | Data length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| rd_ack | input | 1 | Buffer read acknowledge, one clock wide |
| rx_data | output | 9 | Buffered character |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Parity mismatch on the buffered character |
| err_frame | output | 1 | First stop bit of the buffered character was low |
| err_overrun | output | 1 | A character was lost while the buffer was full |
| break_det | output | 1 | Buffered character was an all-low frame |

## Verification
The assertions assume a few things about the inputs. The configuration inputs do not change while a frame is in progress. tick16 is a single-clock strobe with at least three idle clocks between strobes, so the synchronizer settles between strobes. rd_ack is a single-clock pulse. The bench meets all of this. It generates tick16 every fourth clock and sets the configuration only while the line idles between frames. It changes rx_in only on the falling edge of a strobe cycle, so each level it drives is seen at exactly one known strobe. It pulses rd_ack for one clock, and only after it has sampled the buffer.

// File: rtl/uart_mv_rx_pkg.sv
package uart_mv_rx_pkg;

  localparam int CHAR_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;

  function automatic logic [3:0] data_len(input logic [1:0] sel);
    case (sel)
      2'd0:    data_len = 4'd7;
      2'd2:    data_len = 4'd9;
      default: data_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler #(
  parameter int OSR = 16,
  parameter int MID = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic rx,
  output logic vote_stb,
  output logic vote_bit,
  output logic vote_all_low
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] SMP_A = CW'(MID - 1);
  localparam logic [CW-1:0] SMP_B = CW'(MID);
  localparam logic [CW-1:0] SMP_C = CW'(MID + 1);

  logic [CW-1:0] cnt_q, cnt_d, tick_no;
  logic [1:0]    smp_q, smp_d;
  logic          adv;

  assign adv     = active & tick;
  assign tick_no = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    smp_d = smp_q;
    if (!active) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = tick_no;
      if (tick_no == SMP_A) smp_d[0] = rx;
      if (tick_no == SMP_B) smp_d[1] = rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end

  assign vote_stb     = adv & (tick_no == SMP_C);
  assign vote_bit     = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx) | (smp_q[1] & rx);
  assign vote_all_low = ~(smp_q[0] | smp_q[1] | rx);

  // R3: one vote per bit time, never on adjacent clocks
  p_vote_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vote_stb |=> !vote_stb);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_mv_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       vote_stb,
  input  logic       vote_bit,
  input  logic       vote_all_low,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  output logic       active,
  output logic       done,
  output rx_char_t   char_out
);
  rx_state_e         state_q, state_d;
  logic [3:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              par_q, par_d;
  logic              stop1_q, stop1_d;
  logic [3:0]        len;
  logic              stop1_eff;

  assign len = data_len(cfg_dbits);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    data_d  = data_q;
    par_d   = par_q;
    stop1_d = stop1_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: if (tick && !rx) state_d = ST_START;
      ST_START: if (vote_stb) begin
        if (vote_all_low) begin
          state_d = ST_DATA;
          idx_d   = '0;
          data_d  = '0;
          par_d   = 1'b0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_DATA: if (vote_stb) begin
        data_d[idx_q] = vote_bit;
        if (idx_q == len - 4'd1) state_d = cfg_par_en ? ST_PAR : ST_STOP1;
        else                     idx_d   = idx_q + 4'd1;
      end
      ST_PAR: if (vote_stb) begin
        par_d   = vote_bit;
        state_d = ST_STOP1;
      end
      ST_STOP1: if (vote_stb) begin
        stop1_d = vote_bit;
        if (cfg_two_stop) state_d = ST_STOP2;
        else begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end
      end
      ST_STOP2: if (vote_stb) begin
        state_d = ST_IDLE;
        done    = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      stop1_q <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      par_q   <= par_d;
      stop1_q <= stop1_d;
    end
  end

  assign active        = (state_q != ST_IDLE);
  assign stop1_eff     = (state_q == ST_STOP1) ? vote_bit : stop1_q;
  assign char_out.data = data_q;
  assign char_out.perr = cfg_par_en & (^data_q ^ par_q ^ cfg_par_odd);
  assign char_out.ferr = ~stop1_eff;
  assign char_out.brk  = (data_q == '0) & ~(cfg_par_en & par_q) & ~stop1_eff;

  // R2: a start check that is not all low abandons the frame
  p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && vote_stb && !vote_all_low) |=> (state_q == ST_IDLE && !done));
  // R4: the data index never reaches the selected length
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q < len));
  // R6: a frame completes only from a stop position
  p_done_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == ST_STOP1 || state_q == ST_STOP2));
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import uart_mv_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_char_t char_in,
  input  logic     rd_ack,
  output logic     ready,
  output rx_char_t char_q,
  output logic     overrun
);
  rx_char_t buf_q, buf_d;
  logic     rdy_q, rdy_d, ovr_q, ovr_d;

  always_comb begin
    buf_d = buf_q;
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    if (done && rdy_q && !rd_ack) begin
      ovr_d = 1'b1;
    end else if (done) begin
      buf_d = char_in;
      rdy_d = 1'b1;
      ovr_d = 1'b0;
    end else if (rd_ack) begin
      rdy_d      = 1'b0;
      ovr_d      = 1'b0;
      buf_d.perr = 1'b0;
      buf_d.ferr = 1'b0;
      buf_d.brk  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  assign ready   = rdy_q;
  assign char_q  = buf_q;
  assign overrun = ovr_q;

  // R7: an unread character stays ready until acknowledged
  p_hold_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !rd_ack) |=> rdy_q);
  // R8: a character arriving on a full buffer leaves the buffer intact
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !rd_ack && done) |=> (ovr_q && $stable(buf_q)));
  // R9: a break always carries a framing error
  p_break_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_q.brk |-> buf_q.ferr);
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import uart_mv_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MID         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic [1:0]        cfg_dbits,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rd_ack,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              break_det
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       rx_s, active, done, vote_stb, vote_bit, vote_all_low;
  rx_char_t   char_new, char_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(rx_in), .q(rx_s)
  );

  rx_sampler #(.OSR(OSR), .MID(MID)) u_smp (
    .clk(clk), .rst_n(rst_core_n), .tick(tick16), .active(active), .rx(rx_s),
    .vote_stb(vote_stb), .vote_bit(vote_bit), .vote_all_low(vote_all_low)
  );

  rx_frame u_frm (
    .clk(clk), .rst_n(rst_core_n), .tick(tick16), .rx(rx_s),
    .vote_stb(vote_stb), .vote_bit(vote_bit), .vote_all_low(vote_all_low),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .active(active), .done(done), .char_out(char_new)
  );

  rx_buffer u_buf (
    .clk(clk), .rst_n(rst_core_n), .done(done), .char_in(char_new),
    .rd_ack(rd_ack), .ready(rx_ready), .char_q(char_buf), .overrun(err_overrun)
  );

  assign rx_data    = char_buf.data;
  assign err_parity = char_buf.perr;
  assign err_frame  = char_buf.ferr;
  assign break_det  = char_buf.brk;
endmodule

// File: tb/uart_mv_rx_test.sv
module uart_mv_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_dbits = 2'd1;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       rd_ack = 1'b0;
  logic [8:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun, break_det;
  logic [1:0] tdiv = 2'd0;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_mv_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .break_det(break_det)
  );

  typedef struct packed {
    logic [1:0] dbits;
    logic       pen, podd, two;
    logic [8:0] data;
    logic       badpar, stop1low, stop2low;
    logic [3:0] glitch;
    logic [8:0] exp_data;
    logic       exp_perr, exp_ferr, exp_brk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1,1'b0,1'b0,1'b0,9'h0A5,1'b0,1'b0,1'b0,4'd0,9'h0A5,1'b0,1'b0,1'b0},
    '{2'd0,1'b1,1'b0,1'b0,9'h05A,1'b0,1'b0,1'b0,4'd0,9'h05A,1'b0,1'b0,1'b0},
    '{2'd2,1'b1,1'b1,1'b1,9'h1C3,1'b0,1'b0,1'b0,4'd0,9'h1C3,1'b0,1'b0,1'b0},
    '{2'd1,1'b1,1'b0,1'b0,9'h037,1'b1,1'b0,1'b0,4'd0,9'h037,1'b1,1'b0,1'b0},
    '{2'd1,1'b0,1'b0,1'b0,9'h081,1'b0,1'b1,1'b0,4'd0,9'h081,1'b0,1'b1,1'b0},
    '{2'd1,1'b0,1'b0,1'b0,9'h000,1'b0,1'b1,1'b0,4'd0,9'h000,1'b0,1'b1,1'b1},
    '{2'd1,1'b1,1'b1,1'b1,9'h000,1'b1,1'b1,1'b0,4'd0,9'h000,1'b1,1'b1,1'b1},
    '{2'd1,1'b0,1'b0,1'b0,9'h06C,1'b0,1'b0,1'b0,4'd3,9'h06C,1'b0,1'b0,1'b0},
    '{2'd1,1'b0,1'b0,1'b1,9'h0F0,1'b0,1'b0,1'b1,4'd0,9'h0F0,1'b0,1'b0,1'b0},
    '{2'd3,1'b0,1'b0,1'b0,9'h0C3,1'b0,1'b0,1'b0,4'd0,9'h0C3,1'b0,1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,9'h100,1'b0,1'b0,1'b0,4'd0,9'h100,1'b0,1'b0,1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive the level that the next strobe after the current one will see
  task automatic drive_slot(input logic v);
    @(negedge clk);
    while (!tick16) @(negedge clk);
    rx_in = v;
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) drive_slot(1'b1);
  endtask

  task automatic send_frame(input vec_t v);
    logic [15:0] bits;
    int nb, nd;
    logic p;
    nd = (v.dbits == 2'd0) ? 7 : (v.dbits == 2'd2) ? 9 : 8;
    bits = '0;
    nb = 0;
    bits[nb++] = 1'b0;
    p = v.podd ^ v.badpar;
    for (int i = 0; i < nd; i++) begin
      bits[nb++] = v.data[i];
      p ^= v.data[i];
    end
    if (v.pen) bits[nb++] = p;
    bits[nb++] = ~v.stop1low;
    if (v.two) bits[nb++] = ~v.stop2low;
    for (int k = 0; k < nb; k++)
      for (int s = 1; s <= 16; s++)
        drive_slot(((v.glitch != 0) && (k == int'(v.glitch)) && (s == 9)) ? ~bits[k] : bits[k]);
    idle_slots(4);
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_dbits = v.dbits;
    cfg_par_en = v.pen;
    cfg_par_odd = v.podd;
    cfg_two_stop = v.two;
  endtask

  task automatic ack;
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: reset state
    chk(rx_ready == 0, "R1 ready", rx_ready, 0);
    chk({err_parity, err_frame, err_overrun, break_det} == 0, "R1 flags",
        {err_parity, err_frame, err_overrun, break_det}, 0);
    chk(rx_data == 0, "R1 data", rx_data, 0);
    idle_slots(4);

    // Table walk: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      apply_cfg(VEC[i]);
      idle_slots(2);
      send_frame(VEC[i]);
      chk(rx_ready == 1, "R7 ready", rx_ready, 1);
      chk(rx_data == VEC[i].exp_data, "R4/R3 data", rx_data, VEC[i].exp_data);
      chk(err_parity == VEC[i].exp_perr, "R5 parity", err_parity, VEC[i].exp_perr);
      chk(err_frame == VEC[i].exp_ferr, "R6 frame", err_frame, VEC[i].exp_ferr);
      chk(break_det == VEC[i].exp_brk, "R9 break", break_det, VEC[i].exp_brk);
      chk(err_overrun == 0, "R8 no overrun", err_overrun, 0);
      ack();
      chk(rx_ready == 0, "R7 ack clears", rx_ready, 0);
      chk({err_parity, err_frame, break_det} == 0, "R7 flags cleared",
          {err_parity, err_frame, break_det}, 0);
      chk(rx_data == VEC[i].exp_data, "R7 data kept", rx_data, VEC[i].exp_data);
    end

    // R2: short low pulse is rejected
    apply_cfg(VEC[0]);
    for (int s = 0; s < 5; s++) drive_slot(1'b0);
    idle_slots(40);
    chk(rx_ready == 0, "R2 short low rejected", rx_ready, 0);
    // R2: two low samples then one high still rejected (slots 1..9 low, slot 10 high)
    for (int s = 0; s < 9; s++) drive_slot(1'b0);
    idle_slots(40);
    chk(rx_ready == 0, "R2 partial start rejected", rx_ready, 0);

    // R8: overrun keeps the first character
    b = VEC[0];
    b.data = 9'h011;
    send_frame(b);
    chk(rx_ready == 1, "R8 first ready", rx_ready, 1);
    b.data = 9'h022;
    b.stop1low = 1'b1;
    send_frame(b);
    chk(err_overrun == 1, "R8 overrun set", err_overrun, 1);
    chk(rx_data == 9'h011, "R8 data kept", rx_data, 9'h011);
    chk(err_frame == 0, "R8 flags kept", err_frame, 0);
    ack();
    chk(err_overrun == 0, "R7 overrun cleared", err_overrun, 0);
    chk(rx_ready == 0, "R8 ready cleared", rx_ready, 0);

    // R2/R3: receiver recovers after rejection and overrun
    b.data = 9'h05C;
    b.stop1low = 1'b0;
    send_frame(b);
    chk(rx_data == 9'h05C, "R3 recovery data", rx_data, 9'h05C);
    ack();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule